// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Cause Unit

This block watches up to 32 general-purpose input pins and records level changes on them as interrupt causes. Each pin has two enable bits, one for low-to-high changes and one for high-to-low changes. Setting both bits makes the pin respond to either direction. Each detected change sets a sticky cause bit. A per-pin event mask selects which cause bits count as pending. The pending bits are ORed into one shared interrupt line.

Software programs the enables and the mask over a simple register bus. It reads the masked pending view and acknowledges events by writing ones to an acknowledge register. The pins are brought through an internal synchronizer. A change is found by comparing the synchronized level with its value one clock earlier. After reset, edge detection stays off until the synchronizer and the history register hold real pin levels, so the reset values cannot fake an edge.

Register offsets (bus_addr) are: rising enable 0x00, falling enable 0x04, event mask 0x08, masked pending 0x0C (read-only), and acknowledge 0x10 (write-only, reads as zero). Bit i of each register belongs to pin i.

Top module: `edge_cause_unit`

## Requirements
- R1: While reset is asserted, all enable, mask and cause state is zero, every register reads zero and irq_o is low.
- R2: If a pin's rising enable bit is set and the pin goes from 0 to 1, its cause bit is set. The bit appears in the pending view after the SYNC_STAGES+1-th rising clock edge, counting from the edge that first samples the new level, and not earlier.
- R3: If a pin's falling enable bit is set and the pin goes from 1 to 0, its cause bit is set.
- R4: If both enable bits of a pin are set, a change in either direction sets its cause bit.
- R5: A change in a direction whose enable bit is clear never sets a cause bit, even if that enable is set later.
- R6: A cause bit stays set after the pin returns to its former level, until it is acknowledged.
- R7: The pending view (0x0C) reads cause AND mask. A cause bit is latched even while its mask bit is 0, and it shows in the pending view once the mask bit is set.
- R8: Writing to 0x10 clears every cause bit written as 1 and leaves bits written as 0 unchanged. Reading 0x10 returns zero.
- R9: If a new edge and an acknowledge of the same bit happen on the same clock edge, the cause bit stays set.
- R10: irq_o is high exactly while the pending view is nonzero.
- R11: A pin that is already high when reset is released does not produce a cause during the first SYNC_STAGES+1 clock edges after release.
- R12: The rising enable, falling enable and mask registers read back the last value written. Unmapped offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Asynchronous pin levels |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Shared interrupt, high while any pending bit is set |

## Verification
A bad cause bit becomes visible at the ports on the clock edge where it goes wrong, as long as its mask bit is set. It shows in both the pending read and irq_o. A bad bit behind a clear mask bit stays hidden until the mask is opened. For that reason the bench opens masks after latching events on masked pins. An error in the synchronizer depth or the edge history appears as a pending bit one cycle early or one cycle late. The bench catches this because its reference model is compared on every clock and the directed checks sample the exact cycle.

// File: rtl/edge_cause_unit.sv
module edge_cause_unit #(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             irq_o
);

  localparam logic [AW-1:0] A_RISE = AW'(8'h00);
  localparam logic [AW-1:0] A_FALL = AW'(8'h04);
  localparam logic [AW-1:0] A_MASK = AW'(8'h08);
  localparam logic [AW-1:0] A_PEND = AW'(8'h0C);
  localparam logic [AW-1:0] A_ACK  = AW'(8'h10);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);

  logic [SYNC_STAGES-1:0][NPINS-1:0] sync_q;
  logic [NPINS-1:0] prev_q, cur, rise_en_q, fall_en_q, mask_q, cause_q;
  logic [NPINS-1:0] edge_vec, clr_vec, pend;
  logic [CW-1:0]    warm_q;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pins_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= cur;
    end
  end

  assign cur   = sync_q[SYNC_STAGES-1];
  assign armed = (warm_q == CW'(WARM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      warm_q <= '0;
    else if (!armed) warm_q <= warm_q + 1'b1;
  end

  assign edge_vec = armed ? ((rise_en_q & cur & ~prev_q) | (fall_en_q & ~cur & prev_q)) : '0;
  assign clr_vec  = (bus_we && bus_addr == A_ACK) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      mask_q    <= '0;
      cause_q   <= '0;
    end else begin
      cause_q <= (cause_q & ~clr_vec) | edge_vec;
      if (bus_we) begin
        case (bus_addr)
          A_RISE:  rise_en_q <= bus_wdata;
          A_FALL:  fall_en_q <= bus_wdata;
          A_MASK:  mask_q    <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  assign pend  = cause_q & mask_q;
  assign irq_o = |pend;

  always_comb begin
    case (bus_addr)
      A_RISE:  bus_rdata = rise_en_q;
      A_FALL:  bus_rdata = fall_en_q;
      A_MASK:  bus_rdata = mask_q;
      A_PEND:  bus_rdata = pend;
      default: bus_rdata = '0;
    endcase
  end

  AST_WARMUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (cause_q == '0)); // R11

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_vec != '0) |=> ((cause_q & $past(edge_vec)) == $past(edge_vec))); // R9

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q != '0) |=> ((cause_q & $past(cause_q) & ~$past(clr_vec)) == ($past(cause_q) & ~$past(clr_vec)))); // R6

  AST_NO_DISABLED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ((cause_q & ~$past(cause_q) & ~($past(rise_en_q) | $past(fall_en_q))) == '0)); // R5

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != '0 && cause_q != '0)); // R10

endmodule

// File: tb/edge_cause_unit_tb.sv
`timescale 1ns/1ps
module edge_cause_unit_tb;
  localparam int SYNC = 2;
  localparam logic [7:0] A_RISE = 8'h00, A_FALL = 8'h04, A_MASK = 8'h08, A_PEND = 8'h0C, A_ACK = 8'h10;

  logic clk = 0, rst_n = 0, bus_we = 0, irq;
  logic [31:0] pins = 32'h1, wdata = 0, rdata;
  logic [7:0] addr = A_PEND;
  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  edge_cause_unit #(.NPINS(32), .SYNC_STAGES(SYNC), .AW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_we(bus_we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

  logic [31:0] m_rise, m_fall, m_mask, m_cause, m_cur, m_prv, m_edg, m_clr;
  logic [31:0] hist[$];
  int n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rise = 0; m_fall = 0; m_mask = 0; m_cause = 0; hist.delete(); n = 0;
    end else begin
      hist.push_front(pins);
      if (hist.size() > 8) void'(hist.pop_back());
      n++;
      m_edg = 0;
      if (n >= SYNC + 2) begin
        m_cur = hist[SYNC]; m_prv = hist[SYNC+1];
        m_edg = (m_rise & m_cur & ~m_prv) | (m_fall & ~m_cur & m_prv);
      end
      m_clr = (bus_we && addr == A_ACK) ? wdata : 32'h0;
      m_cause = (m_cause & ~m_clr) | m_edg;
      if (bus_we) case (addr)
        A_RISE: m_rise = wdata;
        A_FALL: m_fall = wdata;
        A_MASK: m_mask = wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] model_rd(logic [7:0] a);
    case (a)
      A_RISE: return m_rise;
      A_FALL: return m_fall;
      A_MASK: return m_mask;
      A_PEND: return m_cause & m_mask;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk({cur_req, " model rdata"}, rdata, model_rd(addr));
    chk({cur_req, " model irq"}, {31'h0, irq}, {31'h0, |(m_cause & m_mask)});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; bus_we = 1; cyc(); bus_we = 0; addr = A_PEND;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    addr = a; cyc(); chk(tag, rdata, exp); addr = A_PEND;
  endtask

  task automatic wait_n(int k);
    for (int i = 0; i < k; i++) cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    cur_req = "R1";
    rd(A_RISE, 0, "R1 rise reset"); rd(A_FALL, 0, "R1 fall reset");
    rd(A_MASK, 0, "R1 mask reset"); rd(A_PEND, 0, "R1 pend reset");
    chk("R1 irq reset", {31'h0, irq}, 32'h0);
    rst_n = 1;
    cur_req = "R11";
    wr(A_RISE, 32'hFFFF_FFFF); wr(A_MASK, 32'hFFFF_FFFF);
    wait_n(6);
    rd(A_PEND, 0, "R11 no fake edge after reset");

    cur_req = "R2";
    pins = 32'h3; cyc();
    chk("R2 not after 1 edge", rdata, 0); cyc();
    chk("R2 not after 2 edges", rdata, 0); cyc();
    chk("R2 set after 3 edges", rdata, 32'h2);
    chk("R10 irq high", {31'h0, irq}, 32'h1);

    cur_req = "R8";
    pins = 32'h7; wait_n(4);
    wr(A_ACK, 32'h0); rd(A_PEND, 32'h6, "R8 zero write keeps bits");
    wr(A_ACK, 32'h2); rd(A_PEND, 32'h4, "R8 partial clear");
    wr(A_ACK, 32'h4); rd(A_PEND, 32'h0, "R8 full clear");
    chk("R10 irq low", {31'h0, irq}, 32'h0);
    rd(A_ACK, 32'h0, "R8 ack reads zero");

    cur_req = "R6";
    pins = 32'hF; wait_n(4);
    pins = 32'h7; wait_n(4);
    rd(A_PEND, 32'h8, "R6 sticky after return");
    wr(A_ACK, 32'h8);

    cur_req = "R3";
    wr(A_RISE, 32'h0000_000F); wr(A_FALL, 32'h10);
    pins = 32'h17; wait_n(4);
    rd(A_PEND, 32'h0, "R5 disabled rise ignored");
    pins = 32'h07; wait_n(4);
    rd(A_PEND, 32'h10, "R3 fall detected");
    wr(A_ACK, 32'h10);

    cur_req = "R4";
    wr(A_RISE, 32'h2F); wr(A_FALL, 32'h30);
    pins = 32'h27; wait_n(4);
    rd(A_PEND, 32'h20, "R4 rise side");
    wr(A_ACK, 32'h20);
    rd(A_PEND, 32'h0, "R4 cleared");
    pins = 32'h07; wait_n(4);
    rd(A_PEND, 32'h20, "R4 fall side");
    wr(A_ACK, 32'h20);

    cur_req = "R7";
    wr(A_MASK, 32'h0);
    pins = 32'h27; wait_n(4);
    rd(A_PEND, 32'h0, "R7 masked pending hidden");
    chk("R7 irq masked", {31'h0, irq}, 32'h0);
    wr(A_MASK, 32'h20);
    rd(A_PEND, 32'h20, "R7 latched event exposed");
    chk("R10 irq after unmask", {31'h0, irq}, 32'h1);
    wr(A_ACK, 32'h20); wr(A_MASK, 32'hFFFF_FFFF);

    cur_req = "R5";
    wr(A_RISE, 32'h0); wr(A_FALL, 32'h0);
    pins = 32'h107; wait_n(4);
    wr(A_RISE, 32'h100);
    wait_n(3);
    rd(A_PEND, 32'h0, "R5 late enable no event");
    wr(A_RISE, 32'h2F); wr(A_FALL, 32'h30);
    pins = 32'h7; wait_n(4);

    cur_req = "R9";
    pins = 32'h27; cyc(); cyc();
    wr(A_ACK, 32'h20);
    rd(A_PEND, 32'h20, "R9 edge beats clear");
    wr(A_ACK, 32'h20);
    rd(A_PEND, 32'h0, "R9 later clear works");

    cur_req = "R12";
    rd(A_RISE, 32'h2F, "R12 rise readback");
    rd(A_FALL, 32'h30, "R12 fall readback");
    rd(A_MASK, 32'hFFFF_FFFF, "R12 mask readback");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R12 unmapped reads zero");
    rd(A_RISE, 32'h2F, "R12 unmapped write ignored");
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_MASK, 32'hFFFF_FFFF, "R12 pending write ignored");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule